// File: doc/BRIEF.md
# Byte-Register Serial Port

This block is a small serial port peripheral seen by a processor as eight byte-wide registers on word-aligned byte offsets, accessed over a single-cycle read/write bus with no wait states. It carries a fixed character format of one start bit, eight data bits sent least significant first, no parity and one stop bit. The transmitter holds a single character. The receiver keeps up to four characters in a small queue, which software drains by reading the data register until the status register reports the queue empty.

The status register mixes read-only state bits, two writable interrupt enables and two sticky receive error flags. One interrupt line covers both the receive side (data waiting or an error) and the transmit side (room for a new character). The bit rate comes from a 16-bit divisor split across two registers. A bit lasts four times (divisor + 1) clock cycles, so software loads clock / (4 * baud) - 1.

Top module: `uart_byte_regs`

## Requirements
- R1: After reset the status register (byte offset 20) reads 0xA0, the interrupt is low, the serial output is high and the divisor is 3.
- R2: Offsets 0, 4, 8 and 12 read the identification bytes 0x55, 0xA7, 0x3C and 0x01, and writes to them are ignored. An access whose two low address bits are not zero is not decoded: a write changes nothing and a read returns 0.
- R3: Offset 24 holds the low divisor byte and offset 28 the high byte. Both read back as written, and one serial bit lasts 4 * (divisor + 1) clock cycles.
- R4: A byte written to offset 16 while the transmitter is empty is sent as a low start bit, eight data bits least significant first and a high stop bit. The line stays high when idle.
- R5: Status bit 7 (transmitter empty) is 0 from the cycle after an accepted write until the stop bit ends. A write to offset 16 while it is 0 is dropped.
- R6: Each received byte enters a four-entry queue. A read of offset 16 returns the oldest byte and removes it. Status bit 5 is 1 while the queue is empty.
- R7: Status bit 3 is 1 when four bytes are queued, and status bit 4 is 1 when exactly three are queued.
- R8: A byte that arrives while four are queued is dropped and sets status bit 1 (overrun).
- R9: A character whose stop bit samples low is discarded and sets status bit 0 (frame error).
- R10: A write to status sets bit 2 (receive interrupt enable) and bit 6 (transmit interrupt enable) to the written values. A 0 written to bit 0 or bit 1 clears that flag and a 1 leaves it unchanged. Bits 3, 4, 5 and 7 ignore writes.
- R11: The interrupt is high exactly when (bit 2 and (queue not empty or bit 0 or bit 1)) or (bit 6 and bit 7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| irq | output | 1 | Combined receive/transmit interrupt |
| ser_tx | output | 1 | Serial output |
| ser_rx | input | 1 | Serial input |

## Verification
The checker assumes that bus_sel lasts one cycle per access and that ser_rx changes only at character-bit boundaries spaced by the programmed bit time. The sticky-flag and queue-count properties also assume that software never changes the divisor while a character is in flight. The bench drives every access as a one-cycle strobe set up on the falling clock edge. It generates serial characters with a bit time derived from the divisor it last wrote, and it changes the divisor only while both lines are idle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int DIV_W = 16;

  // word index = byte offset / 4; the order is the software-visible map
  localparam logic [2:0] IDX_DATA = 3'd4;
  localparam logic [2:0] IDX_STS  = 3'd5;
  localparam logic [2:0] IDX_DIVL = 3'd6;
  localparam logic [2:0] IDX_DIVH = 3'd7;

  localparam int SB_FERR = 0;
  localparam int SB_OERR = 1;
  localparam int SB_RXIE = 2;
  localparam int SB_TXIE = 6;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
  } rx_state_e;

  function automatic logic [7:0] pack_status(
    input logic tx_empty, input logic tx_ie, input logic rx_empty,
    input logic rx_one,   input logic rx_full, input logic rx_ie,
    input logic oerr,     input logic ferr);
    return {tx_empty, tx_ie, rx_empty, rx_one, rx_full, rx_ie, oerr, ferr};
  endfunction

  function automatic logic irq_level(
    input logic rx_ie, input logic rx_ready, input logic err_any,
    input logic tx_ie, input logic tx_empty);
    return (rx_ie & (rx_ready | err_any)) | (tx_ie & tx_empty);
  endfunction
endpackage

// File: rtl/sreg_baud_tick.sv
module sreg_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic at_end;

  assign at_end = (cnt >= divisor);
  assign tick   = at_end && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || at_end) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             load,
  input  logic [7:0]       load_byte,
  output logic             busy,
  output logic             line
);
  logic       tick;
  logic [9:0] shreg;
  logic [3:0] left;
  logic [1:0] phase;

  sreg_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(load), .divisor(divisor), .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
      phase <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      shreg <= {1'b1, load_byte, 1'b0};
      left  <= 4'd10;
      phase <= '0;
    end else if (busy && tick) begin
      phase <= phase + 1'b1;
      if (phase == 2'd3) begin
        if (left == 4'd1) busy <= 1'b0;
        shreg <= {1'b1, shreg[9:1]};
        left  <= left - 1'b1;
      end
    end
  end

  assign line = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx
  import sreg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             line_in,
  output logic             byte_valid,
  output logic [7:0]       byte_out,
  output logic             frame_bad
);
  logic      tick, sync1, rxs;
  logic [1:0] phase;
  logic [2:0] bitn;
  rx_state_e state;

  sreg_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(1'b0), .divisor(divisor), .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rxs   <= 1'b1;
    end else begin
      sync1 <= line_in;
      rxs   <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      phase      <= '0;
      bitn       <= '0;
      byte_out   <= '0;
      byte_valid <= 1'b0;
      frame_bad  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_bad  <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: if (!rxs) begin
            state <= RX_START;
            phase <= '0;
          end
          RX_START: begin
            if (phase == 2'd1) begin
              if (!rxs) begin
                state <= RX_DATA;
                phase <= '0;
                bitn  <= '0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              phase <= phase + 1'b1;
            end
          end
          RX_DATA: begin
            phase <= phase + 1'b1;
            if (phase == 2'd3) begin
              byte_out <= {rxs, byte_out[7:1]};
              bitn     <= bitn + 1'b1;
              if (bitn == 3'd7) state <= RX_STOP;
            end
          end
          RX_STOP: begin
            phase <= phase + 1'b1;
            if (phase == 2'd3) begin
              if (rxs) begin
                byte_valid <= 1'b1;
                state      <= RX_IDLE;
              end else begin
                frame_bad  <= 1'b1;
                state      <= RX_WAIT_HIGH;
              end
            end
          end
          RX_WAIT_HIGH: if (rxs) state <= RX_IDLE;
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sreg_rx_fifo.sv
module sreg_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             one_left
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full     = (count == CNT_FULL);
  assign empty    = (count == '0);
  assign one_left = (count == CNT_FULL - 1'b1);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign dout     = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_byte_regs.sv
module uart_byte_regs
  import sreg_pkg::*;
#(
  parameter logic [31:0] ID_WORD    = 32'h013C_A755,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [15:0] DIV_RESET  = 16'd3,
  localparam int         CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       ser_tx,
  input  logic       ser_rx
);
  logic [7:0] div_lo, div_hi;
  logic [DIV_W-1:0] divisor;
  logic rx_ie, tx_ie, oerr, ferr;

  logic [2:0] idx;
  logic hit, wr_hit, rd_hit, sts_wr;

  logic tx_busy, tx_load;
  logic got_byte, frame_bad;
  logic [7:0] rx_byte, fifo_dout;
  logic [CNT_W-1:0] rx_count;
  logic rx_full, rx_empty, rx_one;
  logic rx_push, fifo_pop, overrun_evt;

  assign divisor = {div_hi, div_lo};
  assign idx     = bus_addr[4:2];
  assign hit     = bus_sel && (bus_addr[1:0] == 2'b00);
  assign wr_hit  = hit && bus_wr;
  assign rd_hit  = hit && !bus_wr;
  assign sts_wr  = wr_hit && (idx == IDX_STS);

  assign tx_load     = wr_hit && (idx == IDX_DATA) && !tx_busy;
  assign rx_push     = got_byte && !rx_full;
  assign overrun_evt = got_byte && rx_full;
  assign fifo_pop    = rd_hit && (idx == IDX_DATA) && !rx_empty;

  sreg_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .load(tx_load),
    .load_byte(bus_wdata), .busy(tx_busy), .line(ser_tx));

  sreg_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .line_in(ser_rx),
    .byte_valid(got_byte), .byte_out(rx_byte), .frame_bad(frame_bad));

  sreg_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte), .pop(fifo_pop),
    .dout(fifo_dout), .count(rx_count), .full(rx_full), .empty(rx_empty),
    .one_left(rx_one));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo <= DIV_RESET[7:0];
      div_hi <= DIV_RESET[15:8];
      rx_ie  <= 1'b0;
      tx_ie  <= 1'b0;
      oerr   <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      if (wr_hit && idx == IDX_DIVL) div_lo <= bus_wdata;
      if (wr_hit && idx == IDX_DIVH) div_hi <= bus_wdata;
      if (sts_wr) begin
        rx_ie <= bus_wdata[SB_RXIE];
        tx_ie <= bus_wdata[SB_TXIE];
      end
      oerr <= overrun_evt | (oerr & ~(sts_wr & ~bus_wdata[SB_OERR]));
      ferr <= frame_bad   | (ferr & ~(sts_wr & ~bus_wdata[SB_FERR]));
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_hit) begin
      case (idx)
        IDX_DATA: bus_rdata = fifo_dout;
        IDX_STS:  bus_rdata = pack_status(!tx_busy, tx_ie, rx_empty, rx_one,
                                          rx_full, rx_ie, oerr, ferr);
        IDX_DIVL: bus_rdata = div_lo;
        IDX_DIVH: bus_rdata = div_hi;
        default:  bus_rdata = ID_WORD[{idx[1:0], 3'b000} +: 8];
      endcase
    end
  end

  assign irq = irq_level(rx_ie, !rx_empty, oerr | ferr, tx_ie, !tx_busy);
endmodule

// File: rtl/uart_byte_regs_chk.sv
module uart_byte_regs_chk #(
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [4:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             irq,
  input logic             ser_tx,
  input logic             tx_busy,
  input logic             tx_load,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_push,
  input logic             fifo_pop,
  input logic             overrun_evt,
  input logic             oerr,
  input logic             ferr,
  input logic             rx_ie,
  input logic             tx_ie
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FIFO_DEPTH);

  logic clr_oerr;
  assign clr_oerr = bus_sel && bus_wr && (bus_addr == 5'd20) && !bus_wdata[1];

  assert_tx_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_tx);

  assert_load_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_busy && !ser_tx));

  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_MAX);

  assert_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && !rx_push) |=> (rx_count == $past(rx_count) - 1'b1));

  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> oerr);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oerr && !clr_oerr) |=> oerr);

  assert_irq_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && (oerr || ferr)) |-> irq);

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !tx_ie) |-> !irq);
endmodule

bind uart_byte_regs uart_byte_regs_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (.*);

// File: tb/uart_byte_regs_test.sv
module uart_byte_regs_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, ser_rx = 1'b1;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, ser_tx;

  int n_checks = 0, n_fail = 0;
  int bit_clk = 16;
  logic [7:0] rd;
  logic [7:0] q[$];
  logic m_oerr;

  uart_byte_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .ser_tx(ser_tx), .ser_rx(ser_rx));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_sts(input bit txe, input bit txie, input int cnt,
                                         input bit rxie, input bit oe, input bit fe);
    logic [7:0] v = 8'h00;
    if (fe)       v = v + 8'h01;
    if (oe)       v = v + 8'h02;
    if (rxie)     v = v + 8'h04;
    if (cnt == 4) v = v + 8'h08;
    if (cnt == 3) v = v + 8'h10;
    if (cnt == 0) v = v + 8'h20;
    if (txie)     v = v + 8'h40;
    if (txe)      v = v + 8'h80;
    return v;
  endfunction

  function automatic int clocks_per_bit(input int div);
    return (div + 1) * 4;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // each bus access starts and ends at a falling edge and spans one rising edge
  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input bit good_stop);
    ser_rx = 1'b0; idle(bit_clk);
    for (int i = 0; i < 8; i++) begin ser_rx = b[i]; idle(bit_clk); end
    ser_rx = good_stop; idle(bit_clk);
    ser_rx = 1'b1; idle(bit_clk);
  endtask

  // called 'skew' falling edges after the one where the start bit is first seen
  task automatic expect_frame(input logic [7:0] exp, input int skew, input string req);
    logic [7:0] got;
    int lows;
    idle(bit_clk/2 - skew);
    check({req, " start bit"}, ser_tx, 1'b0);
    for (int i = 0; i < 8; i++) begin idle(bit_clk); got[i] = ser_tx; end
    idle(bit_clk);
    check({req, " stop bit"}, ser_tx, 1'b1);
    check({req, " data bits"}, got, exp);
    idle(bit_clk/2 + 1);
    lows = 0;
    for (int i = 0; i < 2*bit_clk; i++) begin if (!ser_tx) lows++; @(negedge clk); end
    check("R5 dropped byte not sent", lows, 0);
  endtask

  task automatic send_one(input logic [7:0] b, input string req);
    bus_write(5'd16, b);
    bus_write(5'd16, ~b);
    bus_read(5'd20, rd);
    check("R5 tx empty cleared while busy", rd, exp_sts(0, 0, 0, 0, 0, 0));
    expect_frame(b, 2, req);
    bus_read(5'd20, rd);
    check("R5 tx empty after frame", rd, exp_sts(1, 0, 0, 0, 0, 0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    bus_read(5'd20, rd); check("R1 status after reset", rd, 8'hA0);
    check("R1 irq after reset", irq, 1'b0);
    check("R1 line idle high", ser_tx, 1'b1);
    bus_read(5'd24, rd); check("R1 divisor low reset", rd, 8'd3);
    bus_read(5'd28, rd); check("R1 divisor high reset", rd, 8'd0);

    // R2 identification bytes, ignored writes, undecoded misaligned access
    bus_read(5'd0,  rd); check("R2 id0", rd, 8'h55);
    bus_read(5'd4,  rd); check("R2 id1", rd, 8'hA7);
    bus_read(5'd8,  rd); check("R2 id2", rd, 8'h3C);
    bus_read(5'd12, rd); check("R2 id3", rd, 8'h01);
    bus_write(5'd4, 8'hEE);
    bus_read(5'd4, rd); check("R2 id write ignored", rd, 8'hA7);
    bus_write(5'd25, 8'h77);
    bus_read(5'd24, rd); check("R2 misaligned write ignored", rd, 8'd3);
    bus_read(5'd25, rd); check("R2 misaligned read zero", rd, 8'h00);

    // R3 divisor registers and bit time
    bus_write(5'd24, 8'h34); bus_write(5'd28, 8'h12);
    bus_read(5'd24, rd); check("R3 divisor low readback", rd, 8'h34);
    bus_read(5'd28, rd); check("R3 divisor high readback", rd, 8'h12);
    bus_write(5'd24, 8'd5); bus_write(5'd28, 8'd0);
    bit_clk = clocks_per_bit(5);
    send_one(8'hC5, "R3 R4 frame at divisor 5");
    bus_write(5'd24, 8'd3);
    bit_clk = clocks_per_bit(3);

    // R4 R5 transmit: directed extremes then random bytes
    send_one(8'h00, "R4 frame 0x00");
    send_one(8'hFF, "R4 frame 0xFF");
    for (int k = 0; k < 4; k++) send_one(8'($urandom), "R4 random frame");

    // R6 single receive
    send_char(8'h96, 1'b1);
    bus_read(5'd20, rd); check("R6 byte waiting", rd, exp_sts(1, 0, 1, 0, 0, 0));
    bus_read(5'd16, rd); check("R6 data read", rd, 8'h96);
    bus_read(5'd20, rd); check("R6 empty after read", rd, exp_sts(1, 0, 0, 0, 0, 0));

    // R7 R8 fill the queue and overrun it
    q.delete();
    for (int k = 0; k < 3; k++) begin q.push_back(8'($urandom)); send_char(q[k], 1'b1); end
    bus_read(5'd20, rd); check("R7 one slot left", rd, exp_sts(1, 0, 3, 0, 0, 0));
    q.push_back(8'h5A); send_char(8'h5A, 1'b1);
    bus_read(5'd20, rd); check("R7 queue full", rd, exp_sts(1, 0, 4, 0, 0, 0));
    send_char(8'hE1, 1'b1);
    bus_read(5'd20, rd); check("R8 overrun flag", rd, exp_sts(1, 0, 4, 0, 1, 0));
    for (int k = 0; k < 4; k++) begin
      bus_read(5'd16, rd); check("R6 R8 oldest first, extra dropped", rd, q[k]);
    end
    bus_read(5'd20, rd); check("R10 overrun sticky after drain", rd, exp_sts(1, 0, 0, 0, 1, 0));
    bus_write(5'd20, 8'h02);
    bus_read(5'd20, rd); check("R10 writing 1 keeps flag", rd, exp_sts(1, 0, 0, 0, 1, 0));
    bus_write(5'd20, 8'h00);
    bus_read(5'd20, rd); check("R10 writing 0 clears flag", rd, exp_sts(1, 0, 0, 0, 0, 0));

    // R9 frame error
    send_char(8'h3C, 1'b0);
    bus_read(5'd20, rd); check("R9 frame error, byte discarded", rd, exp_sts(1, 0, 0, 0, 0, 1));

    // R10 R11 enables and read-only bits, interrupt equation
    bus_write(5'd20, 8'hFF);
    bus_read(5'd20, rd); check("R10 enables set, read-only bits kept", rd, 8'hE5);
    check("R11 irq on error and tx room", irq, 1'b1);
    bus_write(5'd20, 8'h04);
    bus_read(5'd20, rd); check("R10 frame flag cleared", rd, exp_sts(1, 0, 0, 1, 0, 0));
    check("R11 irq low when nothing pending", irq, 1'b0);
    send_char(8'h81, 1'b1);
    check("R11 irq on received byte", irq, 1'b1);
    bus_read(5'd16, rd); check("R6 byte under irq", rd, 8'h81);
    check("R11 irq low after drain", irq, 1'b0);
    bus_write(5'd20, 8'h40);
    check("R11 irq on tx room", irq, 1'b1);
    bus_write(5'd16, 8'h42);
    check("R11 irq low while tx busy", irq, 1'b0);
    idle(11 * bit_clk);
    check("R11 irq back after frame", irq, 1'b1);
    bus_write(5'd20, 8'h00);

    // random receive/read mix against a queue model
    q.delete(); m_oerr = 1'b0;
    for (int k = 0; k < 24; k++) begin
      if (q.size() == 0 || ($urandom % 3) != 0) begin
        logic [7:0] b = 8'($urandom);
        send_char(b, 1'b1);
        if (q.size() < 4) q.push_back(b); else m_oerr = 1'b1;
      end else begin
        bus_read(5'd16, rd); check("R6 random read order", rd, q.pop_front());
      end
      bus_read(5'd20, rd);
      check("R7 R8 random status", rd, exp_sts(1, 0, q.size(), 0, m_oerr, 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule